// File: doc/BRIEF.md
# Expansion-Bus Write Mailbox

This block is a byte-wide slave on an asynchronous, 68000-style expansion bus that has no cycle acknowledge. A host writes one byte to a mailbox word; the block captures that byte when the data strobe ends. It holds the byte steady on a parallel output for a slow microcontroller and raises an interrupt line. The line stays up until the microcontroller pulses an acknowledge. If a second write lands before that acknowledge, the new byte replaces the old one and a sticky overrun flag is set. The host clears the flag by reading a status word.

Chip select, data strobe and read/write come from another clock domain. They pass through two-flop synchronizers before any decision is made. The host's address lines count words, so each byte register takes up two host byte offsets. The mailbox sits at word `MBOX_WORD` and the status register at word `MBOX_WORD+1`. The strobe width is fixed and cannot be stretched. For that reason read data is driven straight from the pins: the output enable and the data select are combinational, so the byte is ready well inside the strobe window.

Top module: `bus_mailbox`

## Requirements
- R1: After reset, `irq` is 0, `overrun` is 0, `mbox_data` is 0x00 and `bus_doe` is 0.
- R2: A write cycle (`bus_cs_n`=0, `bus_rw`=0, `bus_addr`=`MBOX_WORD`) updates `mbox_data` to `bus_din` and sets `irq`. This happens within 4 clocks after `bus_ds_n` rises, and not while `bus_ds_n` is still low.
- R3: The mailbox and `irq` do not change on a write to any other word, on a strobe with `bus_cs_n` high, or on any read cycle.
- R4: Once set, `irq` stays high until `ack` is 1 for one clock. That pulse clears it on the next clock.
- R5: A mailbox write while `irq` is still 1 replaces `mbox_data` with the new byte and sets `overrun` to 1. `overrun` stays at 1 until a status read.
- R6: A read of word `MBOX_WORD+1` returns bit 0 = `irq` and bit 1 = `overrun`, with bits 7..2 = 0. `overrun` returns to 0 within 4 clocks after that read's strobe ends.
- R7: A read of word `MBOX_WORD` returns the held byte and leaves `irq` unchanged.
- R8: `bus_doe` is 1 only while `bus_cs_n`=0, `bus_ds_n`=0 and `bus_rw`=1, and `bus_addr` is either `MBOX_WORD` or `MBOX_WORD+1`. The read byte is valid on `bus_dout` in that same window.
- R9: `mbox_data` changes only in the clock where a mailbox write is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Expansion-range select, active low |
| bus_ds_n | input | 1 | Data strobe, active low |
| bus_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | AW | Word address |
| bus_din | input | 8 | Write data from the host |
| bus_dout | output | 8 | Read data to the host |
| bus_doe | output | 1 | Enables the read-data driver |
| irq | output | 1 | Byte-pending interrupt to the consumer |
| ack | input | 1 | One-clock acknowledge from the consumer |
| mbox_data | output | 8 | Held mailbox byte |
| overrun | output | 1 | Sticky flag: a byte was replaced before it was acknowledged |

## Verification
A wrong qualification decode shows up as a change in `mbox_data` or `irq` within a few clocks after a strobe that should have been ignored. The sweep touches every word address in both read and write mode. Committing on the wrong edge shows up as `irq` rising while the strobe is still held low. A stale or wrongly cleared overrun or pending bit shows up on the very next status read, because the status byte exposes both flags directly.

// File: rtl/bus_mailbox.sv
module bus_mailbox #(
  parameter int AW        = 4,
  parameter int MBOX_WORD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs_n,
  input  logic          bus_ds_n,
  input  logic          bus_rw,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_din,
  output logic [7:0]    bus_dout,
  output logic          bus_doe,
  output logic          irq,
  input  logic          ack,
  output logic [7:0]    mbox_data,
  output logic          overrun
);

  localparam logic [AW-1:0] MBOX_A = AW'(MBOX_WORD);
  localparam logic [AW-1:0] STAT_A = AW'(MBOX_WORD + 1);

  logic [1:0] cs_sy, ds_sy, rw_sy;
  logic       ds_q;
  logic       wr_armed, st_armed;
  logic [7:0] cap;
  logic       commit_wr, commit_st, sel_mbox, sel_stat, strobe_on;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sy <= 2'b11;
      ds_sy <= 2'b11;
      rw_sy <= 2'b11;
      ds_q  <= 1'b1;
    end else begin
      cs_sy <= {cs_sy[0], bus_cs_n};
      ds_sy <= {ds_sy[0], bus_ds_n};
      rw_sy <= {rw_sy[0], bus_rw};
      ds_q  <= ds_sy[1];
    end

  assign strobe_on = !cs_sy[1] && !ds_sy[1];
  assign commit_wr = ds_sy[1] && !ds_q && wr_armed;
  assign commit_st = ds_sy[1] && !ds_q && st_armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_armed <= 1'b0;
      st_armed <= 1'b0;
      cap      <= 8'h00;
    end else if (ds_sy[1]) begin
      wr_armed <= 1'b0;
      st_armed <= 1'b0;
    end else if (strobe_on) begin
      if (!rw_sy[1] && bus_addr == MBOX_A) begin
        wr_armed <= 1'b1;
        cap      <= bus_din;
      end
      if (rw_sy[1] && bus_addr == STAT_A)
        st_armed <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mbox_data <= 8'h00;
      irq       <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (commit_wr) begin
        mbox_data <= cap;
        irq       <= 1'b1;
        if (irq && !ack) overrun <= 1'b1;
      end else begin
        if (ack) irq <= 1'b0;
        if (commit_st) overrun <= 1'b0;
      end
    end

  assign sel_mbox = bus_addr == MBOX_A;
  assign sel_stat = bus_addr == STAT_A;
  assign bus_doe  = !bus_cs_n && !bus_ds_n && bus_rw && (sel_mbox || sel_stat);
  assign bus_dout = sel_mbox ? mbox_data :
                    sel_stat ? {6'b0, overrun, irq} : 8'h00;

endmodule

module bus_mailbox_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       ack,
  input logic       overrun,
  input logic [7:0] mbox_data,
  input logic       commit_wr
);
  // R2
  capture_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_wr |=> irq);
  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);
  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !commit_wr) |=> !irq);
  // R5
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(irq));
  // R9
  mbox_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_wr |=> $stable(mbox_data));
endmodule

bind bus_mailbox bus_mailbox_chk chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ack(ack), .overrun(overrun),
  .mbox_data(mbox_data), .commit_wr(commit_wr)
);

// File: tb/bus_mailbox_test.sv
module bus_mailbox_test;
  localparam int AW = 4;
  localparam int MW = 2;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, ds_n = 1, rw = 1, ack = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout, mbox;
  logic doe, irq, ovr;
  int checks = 0, errors = 0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  bus_mailbox #(.AW(AW), .MBOX_WORD(MW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_ds_n(ds_n), .bus_rw(rw),
    .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_doe(doe),
    .irq(irq), .ack(ack), .mbox_data(mbox), .overrun(ovr));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d, input logic sel_n);
    @(negedge clk); addr = AW'(a); din = 8'(d); rw = 0; cs_n = sel_n;
    repeat (2) @(negedge clk); ds_n = 0;
    repeat (5) @(negedge clk);
    ds_n = 1;
    repeat (2) @(negedge clk); cs_n = 1; rw = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_read(input int a, output logic [7:0] v, output logic oe);
    @(negedge clk); addr = AW'(a); rw = 1; cs_n = 0;
    repeat (2) @(negedge clk); ds_n = 0;
    repeat (3) @(negedge clk); v = dout; oe = doe;
    repeat (2) @(negedge clk); ds_n = 1;
    repeat (2) @(negedge clk); cs_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_ack;
    @(negedge clk); ack = 1; @(negedge clk); ack = 0; @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic oe;
    repeat (3) @(negedge clk);
    check("R1 irq", irq, 0); check("R1 overrun", ovr, 0);
    check("R1 mbox", mbox, 0); check("R1 doe", doe, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2: strobe held low long -> no irq until it rises
    @(negedge clk); addr = MW; din = 8'h5A; rw = 0; cs_n = 0;
    repeat (2) @(negedge clk); ds_n = 0;
    repeat (10) @(negedge clk);
    check("R2 no irq while strobe low", irq, 0);
    ds_n = 1;
    repeat (4) @(negedge clk);
    check("R2 irq after strobe", irq, 1);
    check("R2 byte", mbox, 8'h5A);
    cs_n = 1; rw = 1;
    // R4: irq holds without ack
    repeat (20) @(negedge clk);
    check("R4 irq holds", irq, 1);
    pulse_ack;
    check("R4 ack clears", irq, 0);

    // R2/R4 sweep all byte values
    for (int v = 0; v < 256; v++) begin
      bus_write(MW, v, 1'b0);
      check("R2 sweep byte", mbox, v);
      check("R2 sweep irq", irq, 1);
      pulse_ack;
      check("R4 sweep ack", irq, 0);
    end
    check("R5 no overrun when acked", ovr, 0);

    // R3: other words, reads, deselected strobes
    for (int a = 0; a < (1 << AW); a++) begin
      if (a != MW) begin
        bus_write(a, 8'hC3, 1'b0);
        check("R3 other word mbox", mbox, 8'hFF);
        check("R3 other word irq", irq, 0);
      end
      bus_read(a, rd, oe);
      check("R8 doe decode", oe, (a == MW || a == MW + 1) ? 1 : 0);
      check("R3 read no effect", irq, 0);
    end
    bus_write(MW, 8'h11, 1'b1);
    check("R3 cs high mbox", mbox, 8'hFF);
    check("R3 cs high irq", irq, 0);
    check("R8 doe idle", doe, 0);

    // R7
    bus_write(MW, 8'hA7, 1'b0);
    bus_read(MW, rd, oe);
    check("R7 read byte", rd, 8'hA7);
    check("R7 irq kept", irq, 1);
    bus_read(MW + 1, rd, oe);
    check("R6 status pending", rd, 8'h01);

    // R5 overrun
    bus_write(MW, 8'h3C, 1'b0);
    check("R5 overwrite", mbox, 8'h3C);
    check("R5 overrun set", ovr, 1);
    pulse_ack;
    check("R5 overrun sticky", ovr, 1);
    bus_read(MW + 1, rd, oe);
    check("R6 status overrun", rd, 8'h02);
    check("R6 overrun cleared", ovr, 0);
    bus_read(MW + 1, rd, oe);
    check("R6 status clear", rd, 8'h00);
    bus_write(MW, 8'h01, 1'b0);
    bus_write(MW, 8'h02, 1'b0);
    bus_read(MW + 1, rd, oe);
    check("R6 status both", rd, 8'h03);
    check("R9 last byte kept", mbox, 8'h02);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule